// File: doc/BRIEF.md
# Crypto Descriptor Intake Validator

This block sits at the front of a symmetric crypto engine. It receives one command, made of two 64-bit words that point at a control descriptor and at a packet descriptor. Alongside the command it takes the instruction word and packet parameters that have already been fetched: packet length, cipher, IV, auth and checksum offsets, hash byte count and a pad flag. It applies a fixed set of legality rules to these inputs. It then builds a two-word completion message that carries a 9-bit control error code and a 9-bit data error code. The descriptor addresses come back in this message, aligned to 32-byte lines.

Commands arrive on a valid/ready handshake. The completion leaves on a second valid/ready handshake, one cycle after the command is accepted. The block holds a single completion. It does not accept a new command until the held completion has been taken.

Top module: `desc_intake_check`

## Requirements
- R1: Each completion word has the following layout:
  - bits 63:61: the framing value (SOP for word 0, EOP for word 1).
  - bits 60:54: the destination id taken from command word 0 bits 60:54 (the same id in both words).
  - bits 53:52: zero.
  - bits 51:49: the ctrl field of the matching command word (bits 63:61).
  - bits 48:40: the error code (control code in word 0, data code in word 1).
  - bits 39:0: the command word's bits 39:0 with bits 4:0 forced to zero.
- R2: Control error bit 0x001 is set when the cipher field (instruction bits 34:32) is 6 or 7.
- R3: Control error bit 0x002 is set when the mode field (instruction bits 31:29) is 5, 6 or 7, or when it is 2, 3 or 4 and the cipher is not AES. The AES cipher values are 3, 4 and 5.
- R4: Control error bit 0x010 is set when any instruction bit in 63:37 or 15:14 is one.
- R5: Control error bit 0x100 is set when command word 0 ctrl differs from SOP (default 3'b001) or command word 1 ctrl differs from EOP (default 3'b010).
- R6: Data error bit 0x001 is set when the packet length is less than or equal to the cipher offset, or less than or equal to the IV offset.
- R7: Data error bit 0x002 is set when the cipher offset is below the IV offset. It is also set when the cipher offset is less than or equal to the IV offset, the cipher is AES and the mode is not CTR (mode value 4).
- R8: Data error bit 0x004 is set when the cipher is AES and packet length bit 3 differs from cipher offset bit 0.
- R9: Data error bit 0x008 is set when the hash byte count is nonzero and the pad flag is low.
- R10: Data error bit 0x010 is set when twice the packet length is less than or equal to the checksum offset. Data error bit 0x040 is set when the packet length is less than or equal to the auth offset.
- R11: When the load flag (command word 1 bit 45) is low, the operation is aborted and the data code is exactly 0x080. Control checks are unaffected.
- R12: All error bits whose conditions hold are ORed together into their code. A code of zero means success.
- R13: The completion becomes valid one cycle after a command is accepted. It is held unchanged until it is accepted. The command ready output is low while a completion is pending, and commands offered during that time have no effect.
- R14: After reset, no completion is pending and the command ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_w0 | input | 64 | Command word pointing at the control descriptor |
| cmd_w1 | input | 64 | Command word pointing at the packet descriptor |
| instr | input | 64 | Fetched instruction word |
| pkt_len | input | LEN_W | Packet length |
| cipher_off | input | OFF_W | Cipher offset |
| iv_off | input | OFF_W | IV offset |
| auth_off | input | OFF_W | Authentication offset |
| cksum_off | input | OFF_W | Checksum offset |
| hash_cnt | input | HCNT_W | Hash byte count |
| pad_en | input | 1 | Hash padding enable |
| rsp_valid | output | 1 | Completion available |
| rsp_ready | input | 1 | Completion taken |
| rsp_w0 | output | 64 | Completion word for the control descriptor |
| rsp_w1 | output | 64 | Completion word for the packet descriptor |

## Verification
The hardest situation to reach is a new command offered while a completion is stalled. In that case the block must ignore the command, and the held words must not move. The stimulus raises cmd_valid with altered words during a stretch of held-off rsp_ready, then checks that the codes still match the earlier command. The AES boundary cases need exact operand choices. For the IV rule, equal cipher and IV offsets are tried under CBC and under CTR. For the wordcount parity, packet lengths 64 and 72 are tried against an even cipher offset, under AES and under DES. The abort case is combined with length violations to show that the abort code replaces the other data bits.

// File: rtl/desc_intake_pkg.sv
package desc_intake_pkg;
    localparam int WORD_W = 64;
    localparam int ADDR_W = 40;
    localparam int ALIGN_W = 5;
    localparam int CODE_W = 9;

    localparam logic [2:0] CIPH_AES_LO = 3'd3;
    localparam logic [2:0] CIPH_AES_HI = 3'd5;
    localparam logic [2:0] MODE_CTR = 3'd4;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
    } rsp_state_t;
endpackage

// File: rtl/desc_ctl_check.sv
module desc_ctl_check
    import desc_intake_pkg::*;
#(
    parameter logic [2:0] SOP = 3'b001,
    parameter logic [2:0] EOP = 3'b010
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [2:0]        ctrl0,
    input  logic [2:0]        ctrl1,
    output logic              is_aes,
    output logic              is_ctr,
    output logic [CODE_W-1:0] code
);
    logic [2:0] ciph;
    logic [2:0] mode;

    always_comb begin
        ciph   = instr[34:32];
        mode   = instr[31:29];
        is_aes = (ciph >= CIPH_AES_LO) && (ciph <= CIPH_AES_HI);
        is_ctr = (mode == MODE_CTR);
        code   = '0;
        code[0] = (ciph == 3'd6) || (ciph == 3'd7);
        code[1] = (mode >= 3'd5) || ((mode >= 3'd2) && !is_aes);
        code[4] = (|instr[63:37]) || (|instr[15:14]);
        code[8] = (ctrl0 != SOP) || (ctrl1 != EOP);
    end
endmodule

// File: rtl/desc_data_check.sv
module desc_data_check
    import desc_intake_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int OFF_W  = 16,
    parameter int HCNT_W = 8
) (
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [OFF_W-1:0]  cipher_off,
    input  logic [OFF_W-1:0]  iv_off,
    input  logic [OFF_W-1:0]  auth_off,
    input  logic [OFF_W-1:0]  cksum_off,
    input  logic [HCNT_W-1:0] hash_cnt,
    input  logic              pad_en,
    input  logic              load,
    input  logic              is_aes,
    input  logic              is_ctr,
    output logic [CODE_W-1:0] code
);
    localparam int CMP_W = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

    logic [CMP_W-1:0] len_x, dbl_x, coff_x, ivo_x, auth_x, cks_x;

    always_comb begin
        len_x  = CMP_W'(pkt_len);
        dbl_x  = CMP_W'({pkt_len, 1'b0});
        coff_x = CMP_W'(cipher_off);
        ivo_x  = CMP_W'(iv_off);
        auth_x = CMP_W'(auth_off);
        cks_x  = CMP_W'(cksum_off);
        code   = '0;
        if (!load) begin
            code[7] = 1'b1;
        end else begin
            code[0] = (len_x <= coff_x) || (len_x <= ivo_x);
            code[1] = (coff_x < ivo_x) || ((coff_x <= ivo_x) && is_aes && !is_ctr);
            code[2] = is_aes && (pkt_len[3] != cipher_off[0]);
            code[3] = (hash_cnt != '0) && !pad_en;
            code[4] = (dbl_x <= cks_x);
            code[6] = (len_x <= auth_x);
        end
    end
endmodule

// File: rtl/desc_rsp_fmt.sv
module desc_rsp_fmt
    import desc_intake_pkg::*;
(
    input  logic [2:0]        frame,
    input  logic [6:0]        dst_id,
    input  logic [2:0]        dsc_ctrl,
    input  logic [CODE_W-1:0] code,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = {frame, dst_id, 2'b00, dsc_ctrl, code,
                addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/desc_intake_check.sv
module desc_intake_check
    import desc_intake_pkg::*;
#(
    parameter int         LEN_W  = 16,
    parameter int         OFF_W  = 16,
    parameter int         HCNT_W = 8,
    parameter logic [2:0] SOP    = 3'b001,
    parameter logic [2:0] EOP    = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [63:0]       cmd_w0,
    input  logic [63:0]       cmd_w1,
    input  logic [63:0]       instr,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [OFF_W-1:0]  cipher_off,
    input  logic [OFF_W-1:0]  iv_off,
    input  logic [OFF_W-1:0]  auth_off,
    input  logic [OFF_W-1:0]  cksum_off,
    input  logic [HCNT_W-1:0] hash_cnt,
    input  logic              pad_en,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_w0,
    output logic [63:0]       rsp_w1
);
    localparam int NWORD = 2;

    logic              aes, ctr;
    logic [CODE_W-1:0] ctl_code, dat_code;

    logic [NWORD-1:0][2:0]        frm;
    logic [NWORD-1:0][2:0]        dsc;
    logic [NWORD-1:0][CODE_W-1:0] cod;
    logic [NWORD-1:0][ADDR_W-1:0] adr;
    logic [NWORD-1:0][WORD_W-1:0] wrd;

    rsp_state_t st_d, st_q;

    desc_ctl_check #(.SOP(SOP), .EOP(EOP)) u_ctl (
        .instr  (instr),
        .ctrl0  (cmd_w0[63:61]),
        .ctrl1  (cmd_w1[63:61]),
        .is_aes (aes),
        .is_ctr (ctr),
        .code   (ctl_code)
    );

    desc_data_check #(.LEN_W(LEN_W), .OFF_W(OFF_W), .HCNT_W(HCNT_W)) u_dat (
        .pkt_len    (pkt_len),
        .cipher_off (cipher_off),
        .iv_off     (iv_off),
        .auth_off   (auth_off),
        .cksum_off  (cksum_off),
        .hash_cnt   (hash_cnt),
        .pad_en     (pad_en),
        .load       (cmd_w1[45]),
        .is_aes     (aes),
        .is_ctr     (ctr),
        .code       (dat_code)
    );

    assign frm = {EOP, SOP};
    assign dsc = {cmd_w1[63:61], cmd_w0[63:61]};
    assign cod = {dat_code, ctl_code};
    assign adr = {cmd_w1[ADDR_W-1:0], cmd_w0[ADDR_W-1:0]};

    for (genvar gi = 0; gi < NWORD; gi++) begin : g_fmt
        desc_rsp_fmt u_fmt (
            .frame    (frm[gi]),
            .dst_id   (cmd_w0[60:54]),
            .dsc_ctrl (dsc[gi]),
            .code     (cod[gi]),
            .addr     (adr[gi]),
            .word     (wrd[gi])
        );
    end

    always_comb begin
        st_d = st_q;
        if (st_q.valid) begin
            if (rsp_ready) st_d.valid = 1'b0;
        end else if (cmd_valid) begin
            st_d.valid = 1'b1;
            st_d.w0    = wrd[0];
            st_d.w1    = wrd[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_ready = !st_q.valid;
    assign rsp_valid = st_q.valid;
    assign rsp_w0    = st_q.w0;
    assign rsp_w1    = st_q.w1;
endmodule

// File: rtl/desc_intake_sva.sv
module desc_intake_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_w0,
    input logic [63:0] rsp_w1
);
    // R13: a stalled completion keeps its contents
    a_r13_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_w0) && $stable(rsp_w1));

    // R13: no command taken while a completion waits
    a_r13_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R13: an accepted command yields a completion on the next cycle
    a_r13_fill: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> rsp_valid);

    // R1: reserved bits and aligned addresses
    a_r1_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_w0[53:52] == 2'b00) && (rsp_w1[53:52] == 2'b00)
                      && (rsp_w0[4:0] == 5'd0) && (rsp_w1[4:0] == 5'd0));

    // R11: the abort code stands alone
    a_r11_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_w1[47] |-> rsp_w1[48:40] == 9'h080);

    // R1: both words carry the same destination id
    a_r1_same_id: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_w0[60:54] == rsp_w1[60:54]);
endmodule

bind desc_intake_check desc_intake_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_w0    (rsp_w0),
    .rsp_w1    (rsp_w1)
);

// File: tb/tb_desc_intake_check.sv
`timescale 1ns/1ps
module tb_desc_intake_check;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, rsp_ready = 1'b0, pad_en = 1'b0;
    logic [63:0] cmd_w0 = '0, cmd_w1 = '0, instr = '0;
    logic [15:0] pkt_len = '0, cipher_off = '0, iv_off = '0, auth_off = '0, cksum_off = '0;
    logic [7:0]  hash_cnt = '0;
    logic        cmd_ready, rsp_valid;
    logic [63:0] rsp_w0, rsp_w1;

    int checks = 0, errors = 0;
    bit done = 0;
    logic        exp_valid = 1'b0;
    logic [63:0] exp_w0 = '0, exp_w1 = '0;
    logic [63:0] lw0, lw1;

    always #4 clk = ~clk;

    desc_intake_check dut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // behavioural reference of one completion
    task automatic model_words(output logic [63:0] o0, output logic [63:0] o1);
        int c, m, ce, de;
        bit aes;
        c = int'(instr[34:32]);
        m = int'(instr[31:29]);
        aes = (c == 3 || c == 4 || c == 5);
        ce = 0; de = 0;
        if (c > 5) ce += 1;
        if (m > 4 || (m > 1 && !aes)) ce += 2;
        if (instr[63:37] != 0 || instr[15:14] != 0) ce += 16;
        if (cmd_w0[63:61] != 3'b001 || cmd_w1[63:61] != 3'b010) ce += 256;
        if (cmd_w1[45] == 1'b0) de = 128;
        else begin
            if (int'(pkt_len) <= int'(cipher_off) || int'(pkt_len) <= int'(iv_off)) de += 1;
            if (int'(cipher_off) < int'(iv_off) ||
                (int'(cipher_off) <= int'(iv_off) && aes && m != 4)) de += 2;
            if (aes && pkt_len[3] != cipher_off[0]) de += 4;
            if (hash_cnt != 0 && !pad_en) de += 8;
            if (2 * int'(pkt_len) <= int'(cksum_off)) de += 16;
            if (int'(pkt_len) <= int'(auth_off)) de += 64;
        end
        o0 = '0; o1 = '0;
        o0[63:61] = 3'b001; o1[63:61] = 3'b010;
        o0[60:54] = cmd_w0[60:54]; o1[60:54] = cmd_w0[60:54];
        o0[51:49] = cmd_w0[63:61]; o1[51:49] = cmd_w1[63:61];
        o0[48:40] = 9'(ce); o1[48:40] = 9'(de);
        o0[39:5] = cmd_w0[39:5]; o1[39:5] = cmd_w1[39:5];
    endtask

    // cycle model and per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) exp_valid = 1'b0;
        else if (exp_valid) begin
            if (rsp_ready) exp_valid = 1'b0;
        end else if (cmd_valid) begin
            model_words(exp_w0, exp_w1);
            exp_valid = 1'b1;
        end
        #2;
        if (rst_n && !done) begin
            chk("R13 rsp_valid", {63'd0, rsp_valid}, {63'd0, exp_valid});
            chk("R13 cmd_ready", {63'd0, cmd_ready}, {63'd0, !exp_valid});
            if (exp_valid) begin
                chk("R1 word0", rsp_w0, exp_w0);
                chk("R1 word1", rsp_w1, exp_w1);
            end
        end
    end

    function automatic logic [63:0] mk_w0(input logic [2:0] ctl);
        return {ctl, 7'h55, 5'd0, 4'd2, 5'd0, 40'h12_3456_789F};
    endfunction
    function automatic logic [63:0] mk_w1(input logic [2:0] ctl, input logic ld);
        return {ctl, 7'd0, 8'd0, ld, 5'd0, 40'hAB_CDEF_0123};
    endfunction
    function automatic logic [63:0] mk_ins(input logic [2:0] c, input logic [2:0] m,
                                           input logic [63:0] extra);
        logic [63:0] x;
        x = extra;
        x[34:32] = c;
        x[31:29] = m;
        return x;
    endfunction

    task automatic set_pkt(input int pl, input int co, input int io, input int ao,
                           input int ko, input int hc, input logic pd);
        pkt_len = 16'(pl); cipher_off = 16'(co); iv_off = 16'(io);
        auth_off = 16'(ao); cksum_off = 16'(ko); hash_cnt = 8'(hc); pad_en = pd;
    endtask

    // one command; optional stall with junk offered meanwhile
    task automatic run(input logic [63:0] a0, input logic [63:0] a1, input logic [63:0] ins,
                       input logic [8:0] ec, input logic [8:0] ed, input string tag,
                       input int hold);
        @(negedge clk);
        cmd_w0 = a0; cmd_w1 = a1; instr = ins; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (hold > 0) begin
            cmd_w0 = ~a0; instr = 64'hFFFF_0000_0000_0000; pkt_len = 16'd0;
            cmd_valid = 1'b1;
            repeat (hold) @(negedge clk);
            cmd_valid = 1'b0;
        end
        lw0 = rsp_w0; lw1 = rsp_w1;
        chk({tag, " ctl code"}, {55'd0, rsp_w0[48:40]}, {55'd0, ec});
        chk({tag, " data code"}, {55'd0, rsp_w1[48:40]}, {55'd0, ed});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] w0, w1, aescbc;
        w0 = mk_w0(3'b001); w1 = mk_w1(3'b010, 1'b1);
        aescbc = mk_ins(3'd3, 3'd1, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R14 reset cmd_ready", {63'd0, cmd_ready}, 64'd1);

        // R12 success and R1 layout
        set_pkt(64, 2, 1, 0, 0, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h000, "R12 legal", 0);
        chk("R1 word0 layout", lw0, {3'd1, 7'h55, 2'b0, 3'd1, 9'd0, 40'h12_3456_7880});
        chk("R1 word1 layout", lw1, {3'd2, 7'h55, 2'b0, 3'd2, 9'd0, 40'hAB_CDEF_0120});

        run(w0, w1, mk_ins(3'd6, 3'd1, 64'd0), 9'h001, 9'h000, "R2 cipher6", 0);
        run(w0, w1, mk_ins(3'd7, 3'd0, 64'd0), 9'h001, 9'h000, "R2 cipher7", 0);
        run(w0, w1, mk_ins(3'd1, 3'd2, 64'd0), 9'h002, 9'h000, "R3 cfb non-aes", 0);
        run(w0, w1, mk_ins(3'd3, 3'd5, 64'd0), 9'h002, 9'h000, "R3 mode5", 0);
        run(w0, w1, mk_ins(3'd5, 3'd3, 64'd0), 9'h000, 9'h000, "R3 ofb aes ok", 0);
        run(w0, w1, mk_ins(3'd3, 3'd1, 64'h100_0000_0000), 9'h010, 9'h000, "R4 bit40", 0);
        run(w0, w1, mk_ins(3'd3, 3'd1, 64'h4000), 9'h010, 9'h000, "R4 bit14", 0);
        run(mk_w0(3'b010), w1, aescbc, 9'h100, 9'h000, "R5 bad sop", 0);
        run(w0, mk_w1(3'b000, 1'b1), mk_ins(3'd7, 3'd1, 64'd0), 9'h101, 9'h000,
            "R5 R12 combined", 0);

        set_pkt(2, 2, 1, 0, 0, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h001, "R6 len eq cipher off", 0);
        set_pkt(64, 2, 2, 0, 0, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h002, "R7 equal offs cbc", 0);
        run(w0, w1, mk_ins(3'd3, 3'd4, 64'd0), 9'h000, 9'h000, "R7 equal offs ctr", 0);
        set_pkt(64, 1, 2, 0, 0, 0, 1'b0);
        run(w0, w1, mk_ins(3'd1, 3'd1, 64'd0), 9'h000, 9'h002, "R7 cipher below iv", 0);
        set_pkt(72, 2, 1, 0, 0, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h004, "R8 aes parity", 0);
        run(w0, w1, mk_ins(3'd1, 3'd1, 64'd0), 9'h000, 9'h000, "R8 des no parity", 0);
        set_pkt(64, 2, 1, 0, 0, 5, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h008, "R9 no pad", 0);
        set_pkt(64, 2, 1, 0, 0, 5, 1'b1);
        run(w0, w1, aescbc, 9'h000, 9'h000, "R9 pad", 0);
        set_pkt(64, 2, 1, 0, 128, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h010, "R10 cksum", 0);
        set_pkt(64, 2, 1, 0, 127, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h000, "R10 cksum edge", 0);
        set_pkt(64, 2, 1, 64, 0, 0, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h040, "R10 auth", 0);
        set_pkt(2, 2, 3, 9, 9, 1, 1'b0);
        run(w0, mk_w1(3'b010, 1'b0), aescbc, 9'h000, 9'h080, "R11 abort", 0);
        set_pkt(72, 2, 1, 100, 0, 1, 1'b0);
        run(w0, w1, aescbc, 9'h000, 9'h04C, "R12 multi", 0);

        // R13 stall with a competing command offered
        set_pkt(64, 2, 1, 0, 0, 0, 1'b0);
        run(w0, w1, mk_ins(3'd6, 3'd1, 64'd0), 9'h001, 9'h000, "R13 stalled", 5);
        chk("R13 held word0", lw0, {3'd1, 7'h55, 2'b0, 3'd1, 9'h001, 40'h12_3456_7880});
        @(negedge clk);
        chk("R13 junk ignored", {63'd0, rsp_valid}, 64'd0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule